// File: doc/BRIEF.md
# Self-Repairing Cellular Stopwatch Counter

This block is a seconds-and-minutes stopwatch built from a row of identical cells. Every cell carries the whole set of digit programs: a decade counter program and a base-six counter program. Each cell runs the program that matches its coordinate in the row. A cell's coordinate is the number of healthy cells to its left. The first four healthy cells form the seconds units, seconds tens, minutes units and minutes tens digits. The healthy cells to their right stay idle as spares.

When a cell is flagged as faulty, the flag is latched, and every cell to its right recomputes its coordinate one lower. The digit values move to the cells that now hold each coordinate, so the displayed time is kept. Counting then goes on with a spare in the last position. The carry between digits travels along the row, and a faulty cell passes it on unchanged. Once fewer than four healthy cells remain, an error output rises and the missing top digit reads zero.

Top module: `embryo_watch`

## Requirements
- R1: After reset all four digits read 0, the error output is low and no cell is marked faulty.
- R2: Each tick advances the seconds units digit. That digit counts 0..9, and its step from 9 back to 0 advances the seconds tens digit in the same cycle.
- R3: The seconds tens digit counts 0..5. Its step from 5 back to 0 advances the minutes units digit, so 00:59 is followed by 01:00.
- R4: The minutes units digit counts 0..9 and the minutes tens digit counts 0..5, so 59:59 is followed by 00:00.
- R5: In a cycle with no tick and no new fault flag, all digits hold their values.
- R6: A one-cycle fault flag on an active cell is latched until reset. The displayed digits are the same after the repair as before it.
- R7: A tick that arrives in the same cycle as a repair is counted.
- R8: A fault flag on an idle spare cell leaves every digit unchanged and keeps the error output low while four healthy cells remain.
- R9: After a repair, counting continues with correct decade and base-six carries.
- R10: The error output goes high once fewer than four healthy cells remain. The top digit then reads 0 and the three lower digits keep counting, with the minutes units digit wrapping 9 to 0 without a carry.
- R11: The digits output holds digit k in bits [4k+3:4k]. Digit 0 is seconds units, 1 is seconds tens, 2 is minutes units and 3 is minutes tens, each in BCD.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | Advance the time by one second in this cycle |
| faultFlags | input | NUM_CELLS | One bit per cell; a high bit marks that cell faulty (latched) |
| digitsBcd | output | 4*DIGITS | BCD digits, seconds units in the low nibble |
| errSpare | output | 1 | Fewer healthy cells than digit positions |

## Verification
The assertions treat the fault flags as the only source of a repair. They also rely on a cell's displayed value depending only on its coordinate, so a cell's value is never above the maximum of the program chosen by that coordinate. The digit-hold property applies only to cycles with no tick and all flags low. The bench therefore drives every fault as a one-cycle pulse, and every tick as a one-cycle pulse on the falling edge, so each remap and each increment can be tied to a single rising edge.

// File: rtl/embryo_pkg.sv
package embryo_pkg;

  localparam int COORD_W = 4;
  localparam int BCD_W   = 4;

  typedef logic [COORD_W-1:0] coord_t;
  typedef logic [BCD_W-1:0]   digit_t;

  typedef enum logic [1:0] {
    GENE_DECADE = 2'd0,
    GENE_SEXTET = 2'd1,
    GENE_IDLE   = 2'd2
  } gene_t;

  typedef struct packed {
    logic tick;
    logic remap;
  } cellStrobe_t;

  function automatic gene_t selectGene(coord_t coord, coord_t digitCount);
    gene_t g;
    if (coord >= digitCount) g = GENE_IDLE;
    else if (coord[0])       g = GENE_SEXTET;
    else                     g = GENE_DECADE;
    return g;
  endfunction

  function automatic digit_t geneMax(gene_t g);
    digit_t m;
    case (g)
      GENE_DECADE: m = 4'd9;
      GENE_SEXTET: m = 4'd5;
      default:     m = 4'd0;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/embryo_ctrl.sv
module embryo_ctrl
  import embryo_pkg::*;
#(
  parameter int NUM_CELLS = 7,
  parameter int DIGITS    = 4
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               tickEn,
  input  logic [NUM_CELLS-1:0]               faultIn,
  output cellStrobe_t                        strobe,
  output logic [NUM_CELLS-1:0]               healthyCur,
  output logic [NUM_CELLS-1:0]               healthyNext,
  output logic [NUM_CELLS-1:0][COORD_W-1:0]  coordCur,
  output logic [NUM_CELLS-1:0][COORD_W-1:0]  coordNext,
  output logic                               errOut,
  output logic                               enoughNext
);

  localparam coord_t DIGIT_LIMIT = coord_t'(DIGITS);

  logic [NUM_CELLS-1:0] faultMask;
  logic [NUM_CELLS-1:0] maskNext;
  coord_t               countCur;
  coord_t               countNext;

  assign maskNext    = faultMask | faultIn;
  assign healthyCur  = ~faultMask;
  assign healthyNext = ~maskNext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) faultMask <= '0;
    else        faultMask <= maskNext;
  end

  // coordinate of a cell = healthy cells strictly to its left
  always_comb begin
    coord_t accCur;
    coord_t accNext;
    accCur  = '0;
    accNext = '0;
    for (int j = 0; j < NUM_CELLS; j++) begin
      coordCur[j]  = accCur;
      coordNext[j] = accNext;
      accCur  = accCur  + coord_t'(healthyCur[j]);
      accNext = accNext + coord_t'(healthyNext[j]);
    end
    countCur  = accCur;
    countNext = accNext;
  end

  assign strobe.tick  = tickEn;
  assign strobe.remap = (maskNext != faultMask);
  assign errOut       = countCur < DIGIT_LIMIT;
  assign enoughNext   = countNext >= DIGIT_LIMIT;

  // R6: a latched fault never clears before reset
  a_r6_mask_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((faultMask & $past(faultMask)) == $past(faultMask)));

  // R6: a flag seen at an edge is recorded by that edge
  a_r6_flag_latched: assert property (@(posedge clk) disable iff (!rst_n)
    (|faultIn) |=> ((faultMask & $past(faultIn)) == $past(faultIn)));

endmodule

// File: rtl/embryo_cell.sv
module embryo_cell
  import embryo_pkg::*;
#(
  parameter int DIGITS = 4
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   carryIn,
  input  logic   healthy,
  input  coord_t coord,
  input  logic   healthyNext,
  input  coord_t coordNext,
  input  logic   remap,
  input  digit_t remapVal,
  output digit_t value,
  output digit_t incVal,
  output logic   carryPass
);

  localparam coord_t DIGIT_LIMIT = coord_t'(DIGITS);

  gene_t  geneNow;
  gene_t  geneLater;
  digit_t maxVal;
  logic   active;
  logic   wrap;
  logic   keepNext;

  assign geneNow   = selectGene(coord, DIGIT_LIMIT);
  assign geneLater = selectGene(coordNext, DIGIT_LIMIT);
  assign maxVal    = geneMax(geneNow);
  assign active    = healthy && (geneNow != GENE_IDLE);
  assign keepNext  = healthyNext && (geneLater != GENE_IDLE);

  assign wrap      = active && carryIn && (value == maxVal);
  assign incVal    = (active && carryIn) ? (wrap ? '0 : value + digit_t'(1)) : value;
  // a faulty cell is bypassed: the carry skips over it
  assign carryPass = healthy ? wrap : carryIn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        value <= '0;
    else if (!keepNext) value <= '0;
    else if (remap)    value <= remapVal;
    else               value <= incVal;
  end

  // R2: an active digit never exceeds the limit of its gene
  a_r2_digit_range: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (value <= maxVal));

  // R8: idle or faulty cells carry no count
  a_r8_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (value == '0));

endmodule

// File: rtl/embryo_datapath.sv
module embryo_datapath
  import embryo_pkg::*;
#(
  parameter int NUM_CELLS = 7,
  parameter int DIGITS    = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  cellStrobe_t                       strobe,
  input  logic [NUM_CELLS-1:0]              healthyCur,
  input  logic [NUM_CELLS-1:0]              healthyNext,
  input  logic [NUM_CELLS-1:0][COORD_W-1:0] coordCur,
  input  logic [NUM_CELLS-1:0][COORD_W-1:0] coordNext,
  input  logic                              enoughNext,
  output logic [DIGITS*BCD_W-1:0]           digitsOut
);

  logic [NUM_CELLS:0]                  carryChain;
  logic [NUM_CELLS-1:0][BCD_W-1:0]     cellVal;
  logic [NUM_CELLS-1:0][BCD_W-1:0]     incVal;
  logic [NUM_CELLS-1:0][BCD_W-1:0]     remapSrc;

  assign carryChain[0] = strobe.tick;

  for (genvar j = 0; j < NUM_CELLS; j++) begin : g_cell
    embryo_cell #(.DIGITS(DIGITS)) u_cell (
      .clk        (clk),
      .rst_n      (rst_n),
      .carryIn    (carryChain[j]),
      .healthy    (healthyCur[j]),
      .coord      (coordCur[j]),
      .healthyNext(healthyNext[j]),
      .coordNext  (coordNext[j]),
      .remap      (strobe.remap),
      .remapVal   (remapSrc[j]),
      .value      (cellVal[j]),
      .incVal     (incVal[j]),
      .carryPass  (carryChain[j+1])
    );
  end

  // each cell takes the post-tick value of the cell that held its new coordinate
  always_comb begin
    for (int j = 0; j < NUM_CELLS; j++) begin
      remapSrc[j] = '0;
      for (int i = 0; i < NUM_CELLS; i++) begin
        if (healthyCur[i] && (coordCur[i] == coordNext[j]))
          remapSrc[j] = remapSrc[j] | incVal[i];
      end
    end
  end

  always_comb begin
    digitsOut = '0;
    for (int k = 0; k < DIGITS; k++) begin
      for (int i = 0; i < NUM_CELLS; i++) begin
        if (healthyCur[i] && (coordCur[i] == coord_t'(k)))
          digitsOut[k*BCD_W +: BCD_W] = digitsOut[k*BCD_W +: BCD_W] | cellVal[i];
      end
    end
  end

  // R6: a repair without a tick keeps the displayed time
  a_r6_remap_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.remap && !strobe.tick && enoughNext) |=> $stable(digitsOut));

endmodule

// File: rtl/embryo_watch.sv
module embryo_watch
  import embryo_pkg::*;
#(
  parameter int NUM_CELLS = 7,
  parameter int DIGITS    = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      tickEn,
  input  logic [NUM_CELLS-1:0]      faultFlags,
  output logic [DIGITS*BCD_W-1:0]   digitsBcd,
  output logic                      errSpare
);

  cellStrobe_t                       strobe;
  logic [NUM_CELLS-1:0]              healthyCur;
  logic [NUM_CELLS-1:0]              healthyNext;
  logic [NUM_CELLS-1:0][COORD_W-1:0] coordCur;
  logic [NUM_CELLS-1:0][COORD_W-1:0] coordNext;
  logic                              enoughNext;

  embryo_ctrl #(.NUM_CELLS(NUM_CELLS), .DIGITS(DIGITS)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .tickEn     (tickEn),
    .faultIn    (faultFlags),
    .strobe     (strobe),
    .healthyCur (healthyCur),
    .healthyNext(healthyNext),
    .coordCur   (coordCur),
    .coordNext  (coordNext),
    .errOut     (errSpare),
    .enoughNext (enoughNext)
  );

  embryo_datapath #(.NUM_CELLS(NUM_CELLS), .DIGITS(DIGITS)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .healthyCur (healthyCur),
    .healthyNext(healthyNext),
    .coordCur   (coordCur),
    .coordNext  (coordNext),
    .enoughNext (enoughNext),
    .digitsOut  (digitsBcd)
  );

  // R5: no tick and no flag means the time holds
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tickEn && (faultFlags == '0)) |=> $stable(digitsBcd));

  // R10: once the spares are used up the error stays until reset
  a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    errSpare |=> errSpare);

endmodule

// File: tb/tb_embryo_watch.sv
`timescale 1ns/1ps
module tb_embryo_watch;
  localparam int NUM_CELLS = 7;
  localparam int DIGITS    = 4;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 tickEn = 1'b0;
  logic [NUM_CELLS-1:0] faultFlags = '0;
  logic [15:0]          digitsBcd;
  logic                 errSpare;

  int testsRun = 0;
  int testsFailed = 0;
  int secCount = 0;
  bit exhausted = 1'b0;

  always #2 clk = ~clk;

  embryo_watch #(.NUM_CELLS(NUM_CELLS), .DIGITS(DIGITS)) dut (
    .clk(clk), .rst_n(rst_n), .tickEn(tickEn),
    .faultFlags(faultFlags), .digitsBcd(digitsBcd), .errSpare(errSpare)
  );

  function automatic logic [15:0] expectedBcd();
    int t = secCount % 3600;
    logic [3:0] su, st, mu, mt;
    su = 4'((t % 10));
    st = 4'(((t / 10) % 6));
    mu = 4'(((t / 60) % 10));
    mt = exhausted ? 4'd0 : 4'(((t / 600) % 6));
    return {mt, mu, st, su};
  endfunction

  task automatic checkVal(string req, logic [31:0] act, logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic checkState(string req);
    checkVal(req, 32'(digitsBcd), 32'(expectedBcd()));
    checkVal(req, 32'(errSpare), 32'(exhausted));
  endtask

  task automatic tickN(int n);
    repeat (n) begin
      tickEn = 1'b1;
      @(negedge clk);
      tickEn = 1'b0;
      secCount++;
    end
  endtask

  task automatic pulseFault(int idx, bit withTick);
    faultFlags[idx] = 1'b1;
    tickEn = withTick;
    @(negedge clk);
    faultFlags = '0;
    tickEn = 1'b0;
    if (withTick) secCount++;
  endtask

  task automatic applyReset();
    rst_n = 1'b0;
    tickEn = 1'b0;
    faultFlags = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    secCount = 0;
    exhausted = 1'b0;
  endtask

  task automatic testReset();
    applyReset();
    checkState("R1 reset state");
    checkVal("R11 all nibbles zero", 32'(digitsBcd), 32'h0);
  endtask

  task automatic testUnits();
    tickN(9);
    checkState("R2 units at 9");
    checkVal("R11 low nibble is seconds units", 32'(digitsBcd[3:0]), 32'd9);
    tickN(1);
    checkState("R2 units carry into tens");
    checkVal("R11 seconds tens nibble", 32'(digitsBcd[7:4]), 32'd1);
  endtask

  task automatic testHold();
    repeat (5) @(negedge clk);
    checkState("R5 hold without tick");
  endtask

  task automatic testMinute();
    tickN(49);
    checkState("R3 at 00:59");
    tickN(1);
    checkState("R3 rollover to 01:00");
    checkVal("R11 minutes units nibble", 32'(digitsBcd[11:8]), 32'd1);
  endtask

  task automatic testFullWrap();
    tickN(3599 - secCount);
    checkState("R4 at 59:59");
    tickN(1);
    checkState("R4 wrap to 00:00");
    checkVal("R4 all zero", 32'(digitsBcd), 32'h0);
  endtask

  task automatic testRepairActive();
    tickN(754);
    checkState("R6 before repair 12:34");
    pulseFault(1, 1'b0);
    checkState("R6 repair keeps time");
    repeat (3) @(negedge clk);
    checkState("R6 repair latched");
  endtask

  task automatic testTickWithFault();
    pulseFault(3, 1'b1);
    checkState("R7 tick during repair");
  endtask

  task automatic testIdleSpare();
    pulseFault(6, 1'b0);
    checkState("R8 idle spare fault");
  endtask

  task automatic testCountAfterRepair();
    tickN(70);
    checkState("R9 counting after repair");
    tickN(54);
    checkState("R9 carry through repaired row");
  endtask

  task automatic testExhaust();
    exhausted = 1'b1;
    pulseFault(0, 1'b0);
    checkState("R10 error and top digit cleared");
    tickN(300);
    checkState("R10 lower digits keep counting");
    tickN(120);
    checkState("R10 minutes units wraps without carry");
    checkVal("R10 top digit stays zero", 32'(digitsBcd[15:12]), 32'd0);
  endtask

  task automatic testResetClears();
    applyReset();
    checkState("R1 reset clears faults");
    tickN(11);
    checkState("R1 full row counts after reset");
  endtask

  initial begin
    #(4 * 200000);
    testsFailed++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    @(negedge clk);
    testReset();
    testUnits();
    testHold();
    testMinute();
    testFullWrap();
    testRepairActive();
    testTickWithFault();
    testIdleSpare();
    testCountAfterRepair();
    testExhaust();
    testResetClears();
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule